// File: doc/BRIEF.md
# Packed Calendar Seconds Counter

This block keeps elapsed time as a single 32-bit word that holds separate second, minute, hour and day fields. The fields are not one flat binary count. The block is clocked from the system clock and advances on a reference tick enable, which usually comes from a 32.768 kHz source. When the scaling input is high, a built-in divider lets only one tick in every 32768 advance the count, so the count moves once per second. When the scaling input is low, every reference tick advances the count.

Each advance raises a one-cycle second pulse. A field that wraps raises its own pulse as well: minute, hour or day. Two alarm comparisons look at the new time after each advance. One compares only the time-of-day fields, and the other compares the whole word including the day count. A stopwatch down-counter moves in step with the time and pulses when it reaches zero. A shared load bus writes the time, the alarm or the stopwatch, selected by three load strobes.

Top module: `packed_time_counter`

## Requirements
- R1: The time word packs seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. A cycle with `loadTime` high puts `loadData` on `timeWord` after that clock edge.
- R2: On an advance, seconds go from 59 to 0 and carry into minutes, and minutes go from 59 to 0 and carry into hours. Any other value simply increments.
- R3: An advance that takes the hours field from 23 to 0 also increments the day field.
- R4: With `scaleEn` low, every cycle with `tickEn` high advances the count. A cycle with `tickEn` low never advances it.
- R5: With `scaleEn` high, the count advances only on the 32768th `tickEn` cycle counted since the divider was last cleared. The divider is cleared by reset, by `loadTime`, or while `scaleEn` is low.
- R6: `secPulse` is high for exactly the one cycle that follows each advance. In that same cycle, `minPulse`, `hourPulse` and `dayPulse` are high when the advance wrapped seconds, minutes or hours respectively.
- R7: After an advance, `todAlarmPulse` is high for one cycle when bits 16:0 of the new time equal the alarm register. `dayAlarmPulse` is high only when all 32 bits are equal. The alarm register is written from `loadData` when `loadAlarm` is high.
- R8: The stopwatch is written from `loadData` when `loadWatch` is high. It decrements by one on each advance while it is non-zero. `watchPulse` is high for one cycle after the advance that takes it from 1 to 0.
- R9: The day field wraps from 32767 to 0. This raises the usual day pulse and no other extra event.
- R10: When a load of the time, or of the stopwatch, falls in the same cycle as an advance, the load takes effect and the advance is dropped: no pulse is raised and no field moves. After a time load, a full 32768 scaled ticks pass before the next advance.
- R11: A stopwatch that holds zero stays at zero and never raises `watchPulse`.
- R12: During reset and after it, the time word is zero, the alarm and stopwatch registers are zero, and no pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Reference tick enable, high for one cycle per reference period |
| scaleEn | input | 1 | 1: advance once per 32768 ticks; 0: advance on every tick |
| loadTime | input | 1 | Write `loadData` into the time word |
| loadAlarm | input | 1 | Write `loadData` into the alarm register |
| loadWatch | input | 1 | Write `loadData` into the stopwatch |
| loadData | input | 32 | Shared load value |
| timeWord | output | 32 | Packed running time |
| secPulse | output | 1 | One-cycle pulse after each advance |
| minPulse | output | 1 | One-cycle pulse on seconds wrap |
| hourPulse | output | 1 | One-cycle pulse on minutes wrap |
| dayPulse | output | 1 | One-cycle pulse on hours wrap |
| todAlarmPulse | output | 1 | Time-of-day alarm match |
| dayAlarmPulse | output | 1 | Full-word alarm match |
| watchPulse | output | 1 | Stopwatch reached zero |

## Verification
The stopwatch expiry and both alarm matches can fall on the same advance as a full seconds-minutes-hours-day carry chain. The bench sets this up deliberately: the time is loaded to one second before midnight, the alarm is set to the following midnight, and the stopwatch is set to one. A single tick then has to raise all seven pulses together, and a wrong carry or a late compare shows up as a missing bit. The bench also places a time load in the same cycle as a tick, to check that the load wins the collision and that the divider restarts for a full period.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int WORD_W = 32;
  localparam int SEC_LSB = 0;
  localparam int SEC_W = 6;
  localparam int MIN_LSB = 6;
  localparam int MIN_W = 6;
  localparam int HR_LSB = 12;
  localparam int HR_W = 5;
  localparam int DAY_LSB = 17;
  localparam int DAY_W = 15;
  localparam int TOD_W = DAY_LSB;

  typedef struct packed {
    logic advance;
    logic loadTime;
    logic loadAlarm;
    logic loadWatch;
  } ptcStrobe_t;
endpackage

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       scaleEn,
  input  logic       loadTime,
  input  logic       loadAlarm,
  input  logic       loadWatch,
  output ptcStrobe_t strobe
);
  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] preCnt;
  logic preWrap;
  logic rawAdvance;

  always_comb begin
    preWrap = (preCnt == LAST);
    rawAdvance = tickEn & (~scaleEn | preWrap);
    strobe.advance = rawAdvance & ~loadTime & ~loadWatch;
    strobe.loadTime = loadTime;
    strobe.loadAlarm = loadAlarm;
    strobe.loadWatch = loadWatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (loadTime || !scaleEn) begin
      preCnt <= '0;
    end else if (tickEn) begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
    end
  end

  AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    loadTime |=> (preCnt == '0)); // R10
  AST_ADVANCE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> tickEn); // R4
  AST_SCALED_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (scaleEn && strobe.advance) |=> (preCnt == '0)); // R5
endmodule

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ptcStrobe_t        strobe,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] timeWord,
  output logic              secPulse,
  output logic              minPulse,
  output logic              hourPulse,
  output logic              dayPulse,
  output logic              todAlarmPulse,
  output logic              dayAlarmPulse,
  output logic              watchPulse
);
  localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(59);
  localparam logic [HR_W-1:0] HR_TOP = HR_W'(23);

  logic [SEC_W-1:0] secR;
  logic [MIN_W-1:0] minR;
  logic [HR_W-1:0] hrR;
  logic [DAY_W-1:0] dayR;
  logic [WORD_W-1:0] alarmR;
  logic [WORD_W-1:0] watchR;

  logic secWrap, minWrap, hrWrap;
  logic [SEC_W-1:0] secNext;
  logic [MIN_W-1:0] minNext;
  logic [HR_W-1:0] hrNext;
  logic [DAY_W-1:0] dayNext;
  logic [WORD_W-1:0] wordNext;

  always_comb begin
    secWrap = (secR == SEC_TOP);
    minWrap = secWrap && (minR == MIN_TOP);
    hrWrap = minWrap && (hrR == HR_TOP);
    secNext = secWrap ? '0 : secR + 1'b1;
    minNext = secWrap ? (minWrap ? '0 : minR + 1'b1) : minR;
    hrNext = minWrap ? (hrWrap ? '0 : hrR + 1'b1) : hrR;
    dayNext = hrWrap ? dayR + 1'b1 : dayR;
    wordNext = {dayNext, hrNext, minNext, secNext};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR <= '0;
      minR <= '0;
      hrR <= '0;
      dayR <= '0;
      alarmR <= '0;
      watchR <= '0;
      secPulse <= 1'b0;
      minPulse <= 1'b0;
      hourPulse <= 1'b0;
      dayPulse <= 1'b0;
      todAlarmPulse <= 1'b0;
      dayAlarmPulse <= 1'b0;
      watchPulse <= 1'b0;
    end else begin
      secPulse <= strobe.advance;
      minPulse <= strobe.advance && secWrap;
      hourPulse <= strobe.advance && minWrap;
      dayPulse <= strobe.advance && hrWrap;
      todAlarmPulse <= strobe.advance && (wordNext[TOD_W-1:0] == alarmR[TOD_W-1:0]);
      dayAlarmPulse <= strobe.advance && (wordNext == alarmR);
      watchPulse <= strobe.advance && (watchR == WORD_W'(1));
      if (strobe.loadTime) begin
        secR <= loadData[SEC_LSB +: SEC_W];
        minR <= loadData[MIN_LSB +: MIN_W];
        hrR <= loadData[HR_LSB +: HR_W];
        dayR <= loadData[DAY_LSB +: DAY_W];
      end else if (strobe.advance) begin
        secR <= secNext;
        minR <= minNext;
        hrR <= hrNext;
        dayR <= dayNext;
      end
      if (strobe.loadAlarm) begin
        alarmR <= loadData;
      end
      if (strobe.loadWatch) begin
        watchR <= loadData;
      end else if (strobe.advance && watchR != '0) begin
        watchR <= watchR - 1'b1;
      end
    end
  end

  assign timeWord = {dayR, hrR, minR, secR};

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && secR == SEC_TOP) |=> (secR == '0 && minPulse)); // R2
  AST_DAY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && hrR == HR_TOP && minR == MIN_TOP && secR == SEC_TOP)
      |=> (dayR == DAY_W'($past(dayR) + 1'b1))); // R3
  AST_MIN_WITH_SEC: assert property (@(posedge clk) disable iff (!rstN)
    minPulse |-> secPulse); // R6
  AST_DAYAL_HAS_TOD: assert property (@(posedge clk) disable iff (!rstN)
    dayAlarmPulse |-> todAlarmPulse); // R7
  AST_WATCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (watchR == '0 && !strobe.loadWatch) |=> (!watchPulse && watchR == '0)); // R11
endmodule

// File: rtl/packed_time_counter.sv
module packed_time_counter
  import ptc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        scaleEn,
  input  logic        loadTime,
  input  logic        loadAlarm,
  input  logic        loadWatch,
  input  logic [31:0] loadData,
  output logic [31:0] timeWord,
  output logic        secPulse,
  output logic        minPulse,
  output logic        hourPulse,
  output logic        dayPulse,
  output logic        todAlarmPulse,
  output logic        dayAlarmPulse,
  output logic        watchPulse
);
  ptcStrobe_t strobe;

  ptc_ctrl #(.PRESCALE(PRESCALE)) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .tickEn(tickEn),
    .scaleEn(scaleEn),
    .loadTime(loadTime),
    .loadAlarm(loadAlarm),
    .loadWatch(loadWatch),
    .strobe(strobe)
  );

  ptc_datapath uData (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .loadData(loadData),
    .timeWord(timeWord),
    .secPulse(secPulse),
    .minPulse(minPulse),
    .hourPulse(hourPulse),
    .dayPulse(dayPulse),
    .todAlarmPulse(todAlarmPulse),
    .dayAlarmPulse(dayAlarmPulse),
    .watchPulse(watchPulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (timeWord == '0 && !secPulse && !watchPulse)); // R12
endmodule

// File: tb/packed_time_counter_test.sv
`timescale 1ns/1ps
module packed_time_counter_test;
  localparam int LIM = 32768;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, tickEn, scaleEn, loadTime, loadAlarm, loadWatch;
  logic [31:0] loadData, timeWord;
  logic secPulse, minPulse, hourPulse, dayPulse, todAlarmPulse, dayAlarmPulse, watchPulse;

  packed_time_counter uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .scaleEn(scaleEn),
    .loadTime(loadTime), .loadAlarm(loadAlarm), .loadWatch(loadWatch),
    .loadData(loadData), .timeWord(timeWord), .secPulse(secPulse),
    .minPulse(minPulse), .hourPulse(hourPulse), .dayPulse(dayPulse),
    .todAlarmPulse(todAlarmPulse), .dayAlarmPulse(dayAlarmPulse),
    .watchPulse(watchPulse)
  );

  typedef struct packed {
    logic [31:0] word;
    logic [6:0] pulses;
  } exp_t;

  exp_t expQ[$];
  string tagQ[$];
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  int mPre = 0, mSec = 0, mMin = 0, mHr = 0, mDay = 0;
  logic [31:0] mAlarm = '0;
  logic [31:0] mWatch = '0;

  function automatic logic [31:0] pack(int d, int h, int m, int s);
    return {15'(d), 5'(h), 6'(m), 6'(s)};
  endfunction

  function automatic logic [6:0] actPulses();
    return {secPulse, minPulse, hourPulse, dayPulse, todAlarmPulse, dayAlarmPulse, watchPulse};
  endfunction

  task automatic check(input string tag, input logic [31:0] aw, input logic [31:0] ew,
                       input logic [6:0] ap, input logic [6:0] ep);
    total++;
    if (aw !== ew || ap !== ep) begin
      bad++;
      $display("FAIL %s: time=%h pulses=%b expected time=%h pulses=%b", tag, aw, ap, ew, ep);
    end
  endtask

  // Driver: one cycle of stimulus; the model result is queued for the monitor.
  task automatic cyc(input logic tk, input logic sc, input logic lt, input logic la,
                     input logic lw, input logic [31:0] d, input string tag);
    logic adv;
    logic [6:0] p;
    logic [31:0] nw;
    @(negedge clk);
    tickEn = tk; scaleEn = sc; loadTime = lt; loadAlarm = la; loadWatch = lw; loadData = d;
    adv = tk && (!sc || mPre == LIM - 1) && !lt && !lw;
    p = '0;
    if (lt) begin
      mSec = int'(d[5:0]); mMin = int'(d[11:6]); mHr = int'(d[16:12]); mDay = int'(d[31:17]);
    end else if (adv) begin
      p[6] = 1'b1;
      if (mSec == 59) begin
        mSec = 0; p[5] = 1'b1;
        if (mMin == 59) begin
          mMin = 0; p[4] = 1'b1;
          if (mHr == 23) begin
            mHr = 0; p[3] = 1'b1;
            mDay = (mDay + 1) % 32768;
          end else mHr++;
        end else mMin++;
      end else mSec++;
      nw = pack(mDay, mHr, mMin, mSec);
      if (nw[16:0] == mAlarm[16:0]) p[2] = 1'b1;
      if (nw == mAlarm) p[1] = 1'b1;
    end
    if (lt || !sc) mPre = 0;
    else if (tk) mPre = (mPre == LIM - 1) ? 0 : mPre + 1;
    if (la) mAlarm = d;
    if (lw) mWatch = d;
    else if (adv && mWatch != 0) begin
      if (mWatch == 1) p[0] = 1'b1;
      mWatch = mWatch - 1;
    end
    @(posedge clk);
    #1;
    expQ.push_back('{word: pack(mDay, mHr, mMin, mSec), pulses: p});
    tagQ.push_back(tag);
  endtask

  // Monitor: compares one queued expectation per cycle, away from the edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, timeWord, e.word, actPulses(), e.pulses);
    end
  end

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tickEn = 0; scaleEn = 0; loadTime = 0; loadAlarm = 0; loadWatch = 0; loadData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 in reset", timeWord, '0, actPulses(), '0);
    rstN = 1'b1;
    cyc(1, 0, 0, 0, 0, 0, "R12 first tick after reset");
    cyc(0, 0, 0, 0, 0, 0, "R12 idle");

    // R1 field layout
    cyc(0, 0, 1, 0, 0, pack(5, 7, 8, 9), "R1 load");
    drain();
    check("R1 literal layout", timeWord, 32'h000A7209, actPulses(), '0);

    // R4 ticks with gaps, unscaled
    for (int i = 0; i < 6; i++) cyc(i % 2 == 0, 0, 0, 0, 0, 0, "R4 gapped ticks");

    // R2 / R3 / R6 carry chain
    cyc(0, 0, 1, 0, 0, pack(3, 22, 59, 58), "R2 load");
    cyc(1, 0, 0, 0, 0, 0, "R2 second step");
    cyc(1, 0, 0, 0, 0, 0, "R2 minute carry");
    cyc(0, 0, 1, 0, 0, pack(3, 23, 59, 59), "R3 load");
    cyc(1, 0, 0, 0, 0, 0, "R3 R6 day carry pulses");
    cyc(0, 0, 0, 0, 0, 0, "R6 pulses one cycle");

    // R9 day wrap
    cyc(0, 0, 1, 0, 0, pack(32767, 23, 59, 59), "R9 load");
    cyc(1, 0, 0, 0, 0, 0, "R9 day wrap");
    cyc(0, 0, 0, 0, 0, 0, "R9 quiet after wrap");

    // R7 alarm flavours
    cyc(0, 0, 0, 1, 0, pack(2, 10, 0, 5), "R7 alarm load");
    cyc(0, 0, 1, 0, 0, pack(1, 10, 0, 4), "R7 load other day");
    cyc(1, 0, 0, 0, 0, 0, "R7 time-of-day only");
    cyc(0, 0, 1, 0, 0, pack(2, 10, 0, 4), "R7 load same day");
    cyc(1, 0, 0, 0, 0, 0, "R7 both alarms");
    cyc(1, 0, 0, 0, 0, 0, "R7 no match after");

    // R8 / R11 stopwatch
    cyc(0, 0, 0, 0, 1, 3, "R8 watch load");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, "R8 countdown");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, "R11 idle at zero");
    cyc(0, 0, 0, 0, 1, 0, "R11 load zero");
    cyc(1, 0, 0, 0, 0, 0, "R11 zero stays quiet");

    // Coincidence: carry chain, both alarms and stopwatch on one advance
    cyc(0, 0, 0, 1, 0, pack(4, 0, 0, 0), "R7 midnight alarm");
    cyc(0, 0, 1, 0, 0, pack(3, 23, 59, 59), "R6 load");
    cyc(0, 0, 0, 0, 1, 1, "R8 watch one");
    cyc(1, 0, 0, 0, 0, 0, "R6 R7 R8 all pulses together");

    // R10 load beats advance
    cyc(1, 0, 1, 0, 0, pack(0, 1, 2, 3), "R10 load with tick");
    cyc(1, 0, 0, 0, 1, 2, "R10 watch load with tick");
    cyc(1, 0, 0, 0, 0, 0, "R10 advance resumes");

    // R5 scaled advance and R10 divider clear
    for (int i = 0; i < 100; i++) cyc(1, 1, 0, 0, 0, 0, "R5 partial period");
    cyc(1, 1, 1, 0, 0, pack(0, 0, 0, 0), "R10 load clears divider");
    for (int i = 0; i < LIM; i++) cyc(1, 1, 0, 0, 0, 0, "R5 R10 full period");
    for (int i = 0; i < 50; i++) cyc(i % 3 == 0, 1, 0, 0, 0, 0, "R5 sparse ticks");
    for (int i = 0; i < LIM; i++) cyc(1, 1, 0, 0, 0, 0, "R5 second period");

    drain();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule